// File: doc/BRIEF.md
# Mode-Banked UART Register Decoder

This block is the register front end of a 16550-class serial port. It has an 8-bit data bus and a 3-bit address. The value held in the line control register picks one of three access modes. Each mode lays the same eight addresses over a different set of physical registers: the operational registers, the divisor latches, the enhanced feature register, and the trigger control and trigger level registers.

The block stores the configuration registers and gates writes to them. It multiplexes read data combinationally. Status values (interrupt identification, line status, modem status) come in on input ports. Receive data arrives on a stub port, and a read of it raises a pop strobe. A transmit write raises a load strobe with the byte beside it. Serialization, baud generation, FIFOs and interrupt priority sit outside this block.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset every stored register is 0, `mode` is 0 (operational) and all strobes are low.
- R2: `mode` is 2 when the line control register equals exactly 8'hBF. It is 1 when bit 7 of that register is 1 and the value is anything else. It is 0 when bit 7 is 0, even if the low seven bits match 8'hBF.
- R3: In modes 1 and 2, address 0 reads and writes the divisor low byte and address 1 the divisor high byte; `divisor_o` is {high, low}. In mode 0, address 1 is the interrupt enable register. A write to address 0 in mode 0 pulses `tx_load` in the same cycle with `tx_data` equal to the written byte. A read of address 0 in mode 0 returns `rx_data` and pulses `rx_pop`.
- R4: In mode 2, address 2 reads and writes the enhanced feature register. In modes 0 and 1, a write to address 2 goes to the FIFO control register and a read returns `iir_in`. The enhanced feature register does not change outside mode 2.
- R5: Address 3 reads and writes the line control register in every mode. The new value is visible one clock after the write.
- R6: In modes 0 and 1, address 4 writes the modem control register. Bits 5:0 always take the written value. Bits 7:6 change only while enhanced feature bit 4 is 1. `clk_div4` reflects modem control bit 7.
- R7: While modem control bit 6 and enhanced feature bit 4 are both 1, address 6 reaches the trigger control register and address 7 the trigger level register. Otherwise address 6 reads `msr_in`, with writes ignored, and address 7 is a scratch register.
- R8: Address 5 reads `lsr_in`; writes to it change no register.
- R9: A write in one mode leaves the registers of the other banks unchanged. Divisor writes in mode 0 never occur.
- R10: In mode 2, address 4 reads 0 and writes to it are ignored.
- R11: `data_bits` equals 5 plus line control bits 1:0, so a value of 3 in those bits gives 8. `spec_char_en` reflects enhanced feature bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_data | input | 8 | Received byte from the receive path |
| rx_pop | output | 1 | Receive byte consumed |
| tx_load | output | 1 | Transmit byte load strobe |
| tx_data | output | 8 | Transmit byte |
| iir_in | input | 8 | Interrupt identification value |
| lsr_in | input | 8 | Line status value |
| msr_in | input | 8 | Modem status value |
| mode | output | 2 | Access mode: 0 operational, 1 config A, 2 config B |
| lcr_o | output | 8 | Line control register |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| efr_o | output | 8 | Enhanced feature register |
| mcr_o | output | 8 | Modem control register |
| divisor_o | output | 16 | Baud divisor |
| tcr_o | output | 8 | Trigger control register |
| tlr_o | output | 8 | Trigger level register |
| data_bits | output | 4 | Character length in bits |
| spec_char_en | output | 1 | Special character detection enable |
| clk_div4 | output | 1 | Clock divide-by-4 select |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are known and settled at each rising edge. They also assume that a write and its decoded mode are judged from the line control value held before that edge. The bench drives every input on the falling edge and issues one access per cycle, never raising both strobes together. Each change of mode goes through an explicit line control write, so every bank access is made in a known mode.

// File: rtl/uart_bank_regs.sv
module uart_bank_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  rx_data,
  output logic        rx_pop,
  output logic        tx_load,
  output logic [7:0]  tx_data,
  input  logic [7:0]  iir_in,
  input  logic [7:0]  lsr_in,
  input  logic [7:0]  msr_in,
  output logic [1:0]  mode,
  output logic [7:0]  lcr_o,
  output logic [7:0]  ier_o,
  output logic [7:0]  fcr_o,
  output logic [7:0]  efr_o,
  output logic [7:0]  mcr_o,
  output logic [15:0] divisor_o,
  output logic [7:0]  tcr_o,
  output logic [7:0]  tlr_o,
  output logic [3:0]  data_bits,
  output logic        spec_char_en,
  output logic        clk_div4
);
  localparam logic [7:0] KEY_B    = 8'hBF;
  localparam logic [1:0] MODE_OP  = 2'd0;
  localparam logic [1:0] MODE_A   = 2'd1;
  localparam logic [1:0] MODE_B   = 2'd2;
  localparam int         ENH_BIT  = 4;
  localparam int         TRIG_BIT = 6;

  logic [7:0] lcr, ier, fcr, efr, mcr, dll, dlh, tcr, tlr, scr;
  logic       in_b, in_op, trig_on;

  assign in_b    = (lcr == KEY_B);
  assign in_op   = ~lcr[7];
  assign mode    = in_b ? MODE_B : (in_op ? MODE_OP : MODE_A);
  assign trig_on = mcr[TRIG_BIT] & efr[ENH_BIT];

  assign tx_load = wr_en & (addr == 3'd0) & in_op;
  assign tx_data = wdata;
  assign rx_pop  = rd_en & (addr == 3'd0) & in_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= '0; ier <= '0; fcr <= '0; efr <= '0; mcr <= '0;
      dll <= '0; dlh <= '0; tcr <= '0; tlr <= '0; scr <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: if (!in_op) dll <= wdata;
        3'd1: if (in_op) ier <= wdata; else dlh <= wdata;
        3'd2: if (in_b) efr <= wdata; else fcr <= wdata;
        3'd3: lcr <= wdata;
        3'd4: if (!in_b)
                mcr <= {(efr[ENH_BIT] ? wdata[7:6] : mcr[7:6]), wdata[5:0]};
        3'd6: if (trig_on) tcr <= wdata;
        3'd7: if (trig_on) tlr <= wdata; else scr <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = in_op ? rx_data : dll;
      3'd1:    rdata = in_op ? ier : dlh;
      3'd2:    rdata = in_b ? efr : iir_in;
      3'd3:    rdata = lcr;
      3'd4:    rdata = in_b ? 8'h00 : mcr;
      3'd5:    rdata = lsr_in;
      3'd6:    rdata = trig_on ? tcr : msr_in;
      default: rdata = trig_on ? tlr : scr;
    endcase
  end

  assign lcr_o        = lcr;
  assign ier_o        = ier;
  assign fcr_o        = fcr;
  assign efr_o        = efr;
  assign mcr_o        = mcr;
  assign divisor_o    = {dlh, dll};
  assign tcr_o        = tcr;
  assign tlr_o        = tlr;
  assign data_bits    = 4'd5 + {2'b00, lcr[1:0]};
  assign spec_char_en = efr[5];
  assign clk_div4     = mcr[7];
endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic [1:0]  mode,
  input logic [7:0]  lcr_o,
  input logic [7:0]  efr_o,
  input logic [7:0]  mcr_o,
  input logic [15:0] divisor_o,
  input logic [7:0]  tcr_o
);
  assert_lcr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> (lcr_o == $past(wdata)));

  assert_key_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wdata == 8'hBF) |=> (mode == 2'd2));

  assert_efr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |=> $stable(efr_o));

  assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> $stable(divisor_o));

  assert_mcr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && !efr_o[4]) |=> (mcr_o[7:6] == $past(mcr_o[7:6])));

  assert_tcr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mcr_o[6] && efr_o[4]) |=> $stable(tcr_o));
endmodule

bind uart_bank_regs uart_bank_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mode(mode), .lcr_o(lcr_o), .efr_o(efr_o), .mcr_o(mcr_o),
  .divisor_o(divisor_o), .tcr_o(tcr_o)
);

// File: tb/uart_bank_regs_tb_top.sv
module uart_bank_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0, rx_data = 8'h3C, iir_in = 8'hC2, lsr_in = 8'h60, msr_in = 8'h9D;
  logic [7:0]  rdata, tx_data, lcr_o, ier_o, fcr_o, efr_o, mcr_o, tcr_o, tlr_o;
  logic [15:0] divisor_o;
  logic [1:0]  mode;
  logic [3:0]  data_bits;
  logic        rx_pop, tx_load, spec_char_en, clk_div4;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_pop(rx_pop),
    .tx_load(tx_load), .tx_data(tx_data), .iir_in(iir_in), .lsr_in(lsr_in),
    .msr_in(msr_in), .mode(mode), .lcr_o(lcr_o), .ier_o(ier_o), .fcr_o(fcr_o),
    .efr_o(efr_o), .mcr_o(mcr_o), .divisor_o(divisor_o), .tcr_o(tcr_o),
    .tlr_o(tlr_o), .data_bits(data_bits), .spec_char_en(spec_char_en),
    .clk_div4(clk_div4)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    #1 rd_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mode", mode, 0);
    check("R1 lcr", lcr_o, 0);
    check("R1 efr/mcr", {efr_o, mcr_o}, 0);
    check("R1 divisor", divisor_o, 0);
    check("R1 strobes", {tx_load, rx_pop}, 0);
  endtask

  task automatic t_mode;
    logic [7:0] d;
    wr(3, 8'h80); check("R2 mode A", mode, 1);
    wr(3, 8'hBF); check("R2 mode B", mode, 2);
    rd(3, d);     check("R5 lcr read in B", d, 8'hBF);
    wr(3, 8'h83); check("R2 mode A 83", mode, 1);
    wr(3, 8'h3F); check("R2 low bits match key", mode, 0);
    wr(3, 8'h03); check("R2 op", mode, 0);
    check("R11 data_bits", data_bits, 8);
    check("R5 lcr value", lcr_o, 8'h03);
  endtask

  task automatic t_divisor;
    logic [7:0] d;
    wr(3, 8'h80); wr(0, 8'h34); wr(1, 8'h12);
    check("R3 divisor mode A", divisor_o, 16'h1234);
    rd(1, d); check("R3 dlh read", d, 8'h12);
    wr(3, 8'hBF); wr(0, 8'h56);
    check("R3 divisor mode B", divisor_o, 16'h1256);
    wr(3, 8'h00);
    rd(1, d); check("R3 ier read op", d, 8'h00);
    wr(1, 8'h0F);
    check("R3 ier write", ier_o, 8'h0F);
    check("R9 divisor kept", divisor_o, 16'h1256);
    @(negedge clk); wr_en = 1'b1; addr = 0; wdata = 8'hA5;
    #1 check("R3 tx strobe", {tx_load, tx_data}, {1'b1, 8'hA5});
    @(negedge clk); wr_en = 1'b0;
    check("R9 divisor after tx", divisor_o, 16'h1256);
    @(negedge clk); rd_en = 1'b1; addr = 0;
    #1 check("R3 rx read", {rx_pop, rdata}, {1'b1, 8'h3C});
    #1 rd_en = 1'b0;
  endtask

  task automatic t_efr;
    logic [7:0] d;
    wr(3, 8'hBF); wr(2, 8'h30);
    check("R4 efr write", efr_o, 8'h30);
    check("R11 spec char", spec_char_en, 1);
    check("R9 fcr kept", fcr_o, 8'h00);
    rd(2, d); check("R4 efr read", d, 8'h30);
    wr(3, 8'h00); wr(2, 8'hC1);
    check("R4 fcr write", fcr_o, 8'hC1);
    check("R4 efr kept", efr_o, 8'h30);
    rd(2, d); check("R4 iir read", d, 8'hC2);
  endtask

  task automatic t_mcr;
    logic [7:0] d;
    wr(3, 8'hBF); wr(2, 8'h00);
    wr(3, 8'h80); wr(4, 8'hFF);
    check("R6 gated mcr", mcr_o, 8'h3F);
    wr(3, 8'hBF); wr(2, 8'h10);
    wr(3, 8'h80); wr(4, 8'hC3);
    check("R6 enabled mcr", mcr_o, 8'hC3);
    check("R6 clk_div4", clk_div4, 1);
    wr(3, 8'hBF);
    rd(4, d); check("R10 addr4 reads 0", d, 0);
    wr(4, 8'h00);
    check("R10 mcr kept", mcr_o, 8'hC3);
  endtask

  task automatic t_trig;
    logic [7:0] d;
    wr(3, 8'h00);
    wr(6, 8'h5A); wr(7, 8'h66);
    check("R7 tcr", tcr_o, 8'h5A);
    check("R7 tlr", tlr_o, 8'h66);
    rd(6, d); check("R7 tcr read", d, 8'h5A);
    wr(4, 8'h83);
    wr(7, 8'h77);
    rd(7, d); check("R7 scratch read", d, 8'h77);
    check("R7 tlr kept", tlr_o, 8'h66);
    rd(6, d); check("R7 msr read", d, 8'h9D);
    wr(6, 8'h11);
    check("R7 tcr kept", tcr_o, 8'h5A);
    rd(5, d); check("R8 lsr read", d, 8'h60);
    wr(5, 8'hFF);
    rd(5, d); check("R8 lsr after write", d, 8'h60);
    check("R8 regs kept", {lcr_o, mcr_o, ier_o, fcr_o}, {8'h00, 8'h83, 8'h0F, 8'hC1});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_mode;
    t_divisor;
    t_efr;
    t_mcr;
    t_trig;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule